// File: doc/BRIEF.md
# Self-Healing Approximate Multiply-Accumulate Unit

This block accumulates a vector of products with two cheap multipliers working side by side. In each accepted step, one unsigned 8-bit pair goes to an OR-compressed multiplier. A second pair goes to a multiplier that drops the low nibble of each operand. Both multipliers under-estimate the exact product. A constant held in a register is added to the second product, and that constant is sized so the two mean errors cancel over a long vector. The two products and the offset are summed into one step value, and that value is added to a wide accumulator.

A vector begins with `start`, which clears the result. Each cycle with `valid` high adds one step, and the step that carries `last` closes the vector. A vector also closes by itself when it reaches the maximum length. The result then stays on the output with `done` high until the next `start`. The offset is written through a simple write-enable port. It takes effect on the steps that follow the write.

Top module: `shmac_unit`

## Requirements
- R1: After reset, `acc_out` is 0, `step_cnt` is 0 and `done` is 0, and `valid` is ignored until a `start` is seen.
- R2: The first multiplier forms the 64 partial products `a[j]&b[i]`, each of weight 2^(i+j). It adds exactly all partial products whose weight is at or above column `OR_COLS` (default 7). For each lower column k with k >= `TRUNC` (default 2), bit k of the result is the OR of that column's partial products. Columns below `TRUNC` are zero.
- R3: The second multiplier returns `(c & 8'hF0) * (d & 8'hF0)` exactly.
- R4: Each accepted step adds `m1 + m2 + secv` to `acc_out`, where `secv` is the unsigned 16-bit offset last written with `secv_we`. A write takes effect on the step in the following cycle.
- R5: `start` sets `acc_out` and `step_cnt` to 0 and clears `done` at the next edge. `start` takes priority over a `valid` in the same cycle, and that step is not added.
- R6: A step with `valid` and `last` is added, and `done` rises at the same edge that updates `acc_out`.
- R7: While `done` is high, `valid` does not change `acc_out`, `step_cnt` or `done`, until the next `start`.
- R8: When the 1024th step of a vector is accepted, the vector closes with `done` high even without `last`. `step_cnt` never exceeds 1024.
- R9: `acc_out` is 29 bits wide. 1024 steps of the largest possible step value do not wrap it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| secv_we | input | 1 | Write strobe for the correction offset |
| secv_din | input | 16 | Correction offset value, unsigned |
| start | input | 1 | Clear the result and open a new vector |
| valid | input | 1 | Operands carry one step this cycle |
| last | input | 1 | This step is the final step of the vector |
| a | input | 8 | First operand of the OR-compressed multiplier |
| b | input | 8 | Second operand of the OR-compressed multiplier |
| c | input | 8 | First operand of the nibble-truncating multiplier |
| d | input | 8 | Second operand of the nibble-truncating multiplier |
| acc_out | output | 29 | Accumulated result |
| done | output | 1 | Vector closed; result is final |
| step_cnt | output | 11 | Steps accepted in the current vector |

## Verification
The assertions check the control rules on every cycle:
- a cleared state after `start`;
- a frozen result and count while `done` is high;
- a count bound of 1024;
- an unchanged result in any cycle without a step.

The arithmetic cannot be checked that way. Bit-exact agreement of both approximate products, the offset, and the absence of wrap over a full-length vector of maximum operands are shown only by the bench's scenarios. The bench compares the result against its own model of both multipliers.

// File: rtl/shmac_unit.sv
module shmac_or_mul #(
  parameter int TRUNC   = 2,
  parameter int OR_COLS = 7
) (
  input  logic [7:0]  x,
  input  logic [7:0]  y,
  output logic [15:0] p
);
  logic [15:0] hi, lo;
  always_comb begin
    hi = '0;
    lo = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (i + j >= OR_COLS)
          hi = hi + (16'(x[j] & y[i]) << (i + j));
        else if (i + j >= TRUNC)
          lo[i+j] = lo[i+j] | (x[j] & y[i]);
  end
  assign p = hi + lo;
endmodule

module shmac_nib_mul (
  input  logic [7:0]  x,
  input  logic [7:0]  y,
  output logic [15:0] p
);
  assign p = {x[7:4], 4'b0} * {y[7:4], 4'b0};
endmodule

module shmac_unit #(
  parameter int TRUNC   = 2,
  parameter int OR_COLS = 7,
  parameter int MAX_LEN = 1024,
  parameter int SECV_W  = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ACC_W   = 16 + 1 + $clog2(MAX_LEN) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secv_we,
  input  logic [SECV_W-1:0] secv_din,
  input  logic              start,
  input  logic              valid,
  input  logic              last,
  input  logic [7:0]        a,
  input  logic [7:0]        b,
  input  logic [7:0]        c,
  input  logic [7:0]        d,
  output logic [ACC_W-1:0]  acc_out,
  output logic              done,
  output logic [LEN_W-1:0]  step_cnt
);
  localparam int STEP_W = (SECV_W > 16 ? SECV_W : 16) + 2;

  logic [15:0]       m1, m2;
  logic [SECV_W-1:0] secv;
  logic              armed;
  logic [STEP_W-1:0] step;
  logic              take;

  shmac_or_mul #(.TRUNC(TRUNC), .OR_COLS(OR_COLS)) u_m1 (.x(a), .y(b), .p(m1));
  shmac_nib_mul u_m2 (.x(c), .y(d), .p(m2));

  assign step = STEP_W'(m1) + STEP_W'(m2) + STEP_W'(secv);
  assign take = valid && armed && !start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) secv <= '0;
    else if (secv_we) secv <= secv_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out  <= '0;
      step_cnt <= '0;
      done     <= 1'b0;
      armed    <= 1'b0;
    end else if (start) begin
      acc_out  <= '0;
      step_cnt <= '0;
      done     <= 1'b0;
      armed    <= 1'b1;
    end else if (take) begin
      acc_out  <= acc_out + ACC_W'(step);
      step_cnt <= step_cnt + 1'b1;
      if (last || step_cnt == LEN_W'(MAX_LEN - 1)) begin
        done  <= 1'b1;
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shmac_unit_chk.sv
module shmac_unit_chk #(
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = 11,
  parameter int ACC_W   = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             valid,
  input logic [ACC_W-1:0] acc_out,
  input logic             done,
  input logic [LEN_W-1:0] step_cnt
);
  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_out == '0 && step_cnt == '0 && !done));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(acc_out) && $stable(step_cnt)));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= LEN_W'(MAX_LEN));

  a_r4_no_step_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !start) |=> $stable(acc_out));

  a_r8_full_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt == LEN_W'(MAX_LEN)) |-> done);
endmodule

bind shmac_unit shmac_unit_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
  .acc_out(acc_out), .done(done), .step_cnt(step_cnt)
);

// File: tb/tb_shmac_unit.sv
`timescale 1ns/1ps
module tb_shmac_unit;
  logic clk = 0, rst_n = 0;
  logic secv_we = 0, start = 0, valid = 0, last = 0;
  logic [15:0] secv_din = 0;
  logic [7:0] a = 0, b = 0, c = 0, d = 0;
  logic [28:0] acc_out;
  logic done;
  logic [10:0] step_cnt;

  int n_run = 0, n_fail = 0;
  longint model = 0;
  longint secv_m = 0;
  int seed = 12345;

  always #2.5 clk = ~clk;

  shmac_unit dut (.clk(clk), .rst_n(rst_n), .secv_we(secv_we), .secv_din(secv_din),
    .start(start), .valid(valid), .last(last), .a(a), .b(b), .c(c), .d(d),
    .acc_out(acc_out), .done(done), .step_cnt(step_cnt));

  function automatic longint ref_m1(input int x, input int y);
    longint r = x * y;
    for (int k = 0; k < 7; k++) begin
      int orbit = 0;
      for (int i = 0; i <= k; i++) begin
        int pp = ((x >> (k - i)) & 1) & ((y >> i) & 1);
        r -= longint'(pp) << k;
        orbit |= pp;
      end
      if (k >= 2) r += longint'(orbit) << k;
    end
    return r;
  endfunction

  function automatic longint ref_m2(input int x, input int y);
    return longint'((x / 16) * 16) * longint'((y / 16) * 16);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 255;
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    model = 0;
  endtask

  task automatic do_step(input int x, input int y, input int u, input int v, input bit l);
    @(negedge clk);
    a = 8'(x); b = 8'(y); c = 8'(u); d = 8'(v); valid = 1; last = l;
    @(negedge clk);
    valid = 0; last = 0;
  endtask

  task automatic set_secv(input int v);
    @(negedge clk); secv_we = 1; secv_din = 16'(v);
    @(negedge clk); secv_we = 0;
    secv_m = v;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) @(negedge clk);
    chk("R1 acc", acc_out, 0); chk("R1 cnt", step_cnt, 0); chk("R1 done", done, 0);
    rst_n = 1;
    do_step(200, 200, 200, 200, 1);
    chk("R1 ignored before start", acc_out, 0);
    chk("R1 done stays low", done, 0);
  endtask

  task automatic t_single_products();
    int pat[6][2] = '{'{255,255}, '{0,0}, '{1,1}, '{127,129}, '{15,15}, '{170,85}};
    foreach (pat[p]) begin
      do_start();
      do_step(pat[p][0], pat[p][1], 0, 0, 1);
      chk("R2 m1 product", acc_out, ref_m1(pat[p][0], pat[p][1]));
      do_start();
      do_step(0, 0, pat[p][0], pat[p][1], 1);
      chk("R3 m2 product", acc_out, ref_m2(pat[p][0], pat[p][1]));
    end
  endtask

  task automatic t_vector_secv();
    set_secv(300);
    do_start();
    for (int s = 0; s < 20; s++) begin
      int x = rnd(), y = rnd(), u = rnd(), v = rnd();
      do_step(x, y, u, v, s == 19);
      model += ref_m1(x, y) + ref_m2(u, v) + secv_m;
      if (s == 9) chk("R4 mid count", step_cnt, 10);
    end
    chk("R4 vector sum", acc_out, model);
    chk("R6 done after last", done, 1);
    chk("R6 count", step_cnt, 20);
    do_step(255, 255, 255, 255, 0);
    chk("R7 acc frozen", acc_out, model);
    chk("R7 count frozen", step_cnt, 20);
    set_secv(65535);
    do_start();
    do_step(0, 0, 0, 0, 1);
    chk("R4 offset only", acc_out, 65535);
  endtask

  task automatic t_start_priority();
    set_secv(7);
    do_start();
    do_step(10, 10, 10, 10, 0);
    model = ref_m1(10, 10) + ref_m2(10, 10) + 7;
    chk("R5 pre", acc_out, model);
    @(negedge clk); start = 1; valid = 1; a = 200; b = 200;
    @(negedge clk); start = 0; valid = 0;
    chk("R5 start wins acc", acc_out, 0);
    chk("R5 start wins cnt", step_cnt, 0);
    chk("R5 done low", done, 0);
  endtask

  task automatic t_full_length();
    longint per;
    set_secv(65535);
    do_start();
    per = ref_m1(255, 255) + ref_m2(255, 255) + 65535;
    @(negedge clk); a = 255; b = 255; c = 255; d = 255; valid = 1; last = 0;
    repeat (1023) @(negedge clk);
    chk("R8 not yet closed", done, 0);
    @(negedge clk);
    chk("R8 auto close", done, 1);
    chk("R8 count 1024", step_cnt, 1024);
    chk("R9 no wrap", acc_out, per * 1024);
    @(negedge clk); valid = 0;
    chk("R8 extra ignored", step_cnt, 1024);
  endtask

  initial begin
    t_reset();
    t_single_products();
    t_vector_secv();
    t_start_priority();
    t_full_length();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule